// File: doc/BRIEF.md
# Global-History Correlating Branch Direction Predictor

This block predicts branch direction for a short in-order pipeline. A table of 2-bit saturating up/down counters is indexed by a few low program-counter bits. The global branch-outcome history sits in the low bits of the index. The table is read while the instruction is in fetch. The counter value and the index it came from are captured together in a fetch-to-decode register.

In decode the block drives a taken/not-taken prediction from the most significant bit of the captured counter. When the decode-stage instruction is a branch, the block writes a stepped counter back to the captured index and shifts the resolved outcome into the history register. The new history bit is forwarded into the index being formed in fetch. A counter that is written in the same cycle it is read is bypassed from the write data. With both paths in place, back-to-back branches see exactly the state a strictly sequential predictor would give them.

Top module: `hist_branch_pred`

## Requirements
- R1: The table index is {fetch_pc_i[PC_LO+IDX_W-HIST_W-1:PC_LO], history}, with the HIST_W history bits in the low positions and the PC bits above them.
- R2: pred_taken_o equals the most significant bit of the counter read for the PC presented on fetch_pc_i one clock earlier; 1 means taken, 0 means not taken.
- R3: For a branch in decode, the counter becomes its captured value plus one when dec_taken_i is 1, or minus one when it is 0, saturating at 3 and at 0.
- R4: The stepped counter is written to the index captured at fetch, not to an index recomputed in decode.
- R5: When dec_is_br_i is 1, the history register shifts left by one at the clock edge and takes dec_taken_i into bit 0.
- R6: The index formed in fetch uses the history as updated by the branch currently in decode, so that back-to-back branches see each other's outcomes.
- R7: A fetch read of the entry being written in the same cycle returns the newly written value.
- R8: After reset the history is all zeros, every counter holds 1 (weakly not taken), and pred_taken_o is 0.
- R9: When dec_is_br_i is 0, neither the table nor the history changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_pc_i | input | PC_W | PC of the instruction in fetch |
| dec_is_br_i | input | 1 | Instruction in decode is a branch; enables the counter write and the history shift |
| dec_taken_i | input | 1 | Resolved outcome of the branch in decode (1 = taken) |
| pred_taken_o | output | 1 | Prediction for the instruction in decode (1 = taken) |

## Verification
The bench builds the block with IDX_W=5 and HIST_W=3. This leaves only two PC bits in the index, so many fetch addresses alias onto the same counters. Fetch reads then often hit the entry being written, which exercises the bypass. It also means a decode-time index error would land on a counter that a later prediction reads. The three-bit history fills with directed all-taken and alternating runs, which drive counters into both saturation limits. Back-to-back branches on one PC then exercise the history forwarding.

// File: rtl/bp_pkg.sv
package bp_pkg;
  parameter int unsigned BP_CNT_W = 2;
  typedef logic [BP_CNT_W-1:0] bp_cnt_t;
  localparam bp_cnt_t BP_CNT_MAX = '1;
  localparam bp_cnt_t BP_CNT_MIN = '0;
  localparam bp_cnt_t BP_CNT_RST = bp_cnt_t'(1);

  function automatic bp_cnt_t bp_sat_step(bp_cnt_t c, logic up);
    if (up) return (c == BP_CNT_MAX) ? c : bp_cnt_t'(c + 1'b1);
    else    return (c == BP_CNT_MIN) ? c : bp_cnt_t'(c - 1'b1);
  endfunction
endpackage

// File: rtl/bp_index.sv
module bp_index #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned PC_LO  = 2,
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned HIST_W = 2
) (
  input  logic [PC_W-1:0]   pc_i,
  input  logic [HIST_W-1:0] hist_i,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int unsigned PC_BITS = IDX_W - HIST_W;

  assign idx_o = {pc_i[PC_LO +: PC_BITS], hist_i};

  initial begin
    assert (HIST_W >= 1 && HIST_W < IDX_W && PC_LO + PC_BITS <= PC_W)
      else $error("bp_index: bad parameters");
  end
endmodule

// File: rtl/bp_history.sv
module bp_history #(
  parameter int unsigned HIST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [HIST_W-1:0] hist_o,
  output logic [HIST_W-1:0] hist_next_o
);
  logic [HIST_W-1:0] hist_q;
  logic [HIST_W:0]   shifted;

  assign shifted     = {hist_q, bit_i};
  assign hist_next_o = shift_i ? shifted[HIST_W-1:0] : hist_q;
  assign hist_o      = hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= '0;
    else if (shift_i) hist_q <= shifted[HIST_W-1:0];
  end

  AST_HIST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(hist_q)); // R9
  AST_HIST_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> hist_q[0] == $past(bit_i)); // R5
  AST_HIST_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> hist_q == $past(hist_next_o)); // R6
endmodule

// File: rtl/bp_cnt_table.sv
module bp_cnt_table
  import bp_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] raddr_i,
  output bp_cnt_t          rdata_o,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  bp_cnt_t          wdata_i
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  bp_cnt_t mem_q [DEPTH];

  // same-cycle write to the read entry is bypassed
  assign rdata_o = (we_i && waddr_i == raddr_i) ? wdata_i : mem_q[raddr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= BP_CNT_RST;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  AST_WR_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i)); // R4
endmodule

// File: rtl/hist_branch_pred.sv
module hist_branch_pred
  import bp_pkg::*;
#(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned PC_LO  = 2,
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned HIST_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] fetch_pc_i,
  input  logic            dec_is_br_i,
  input  logic            dec_taken_i,
  output logic            pred_taken_o
);
  logic [HIST_W-1:0] hist, hist_next;
  logic [IDX_W-1:0]  fetch_idx, lat_idx_q;
  bp_cnt_t           fetch_cnt, lat_cnt_q, wr_cnt;

  bp_history #(.HIST_W(HIST_W)) i_hist (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_i    (dec_is_br_i),
    .bit_i      (dec_taken_i),
    .hist_o     (hist),
    .hist_next_o(hist_next)
  );

  // index built from forwarded history
  bp_index #(.PC_W(PC_W), .PC_LO(PC_LO), .IDX_W(IDX_W), .HIST_W(HIST_W)) i_idx (
    .pc_i  (fetch_pc_i),
    .hist_i(hist_next),
    .idx_o (fetch_idx)
  );

  bp_cnt_table #(.IDX_W(IDX_W)) i_tbl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raddr_i(fetch_idx),
    .rdata_o(fetch_cnt),
    .we_i   (dec_is_br_i),
    .waddr_i(lat_idx_q),
    .wdata_i(wr_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_idx_q <= '0;
      lat_cnt_q <= BP_CNT_RST;
    end else begin
      lat_idx_q <= fetch_idx;
      lat_cnt_q <= fetch_cnt;
    end
  end

  assign wr_cnt       = bp_sat_step(lat_cnt_q, dec_taken_i);
  assign pred_taken_o = lat_cnt_q[BP_CNT_W-1];

  AST_SAT_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_is_br_i && dec_taken_i && lat_cnt_q == BP_CNT_MAX |-> wr_cnt == BP_CNT_MAX); // R3
  AST_SAT_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_is_br_i && !dec_taken_i && lat_cnt_q == BP_CNT_MIN |-> wr_cnt == BP_CNT_MIN); // R3
  AST_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_is_br_i && fetch_idx == lat_idx_q |=> lat_cnt_q == $past(wr_cnt)); // R7
  AST_HIST_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> lat_idx_q[HIST_W-1:0] == hist); // R6
endmodule

// File: tb/test_hist_branch_pred.sv
module test_hist_branch_pred;
  localparam int PC_W = 32, PC_LO = 2, IDX_W = 5, HIST_W = 3;
  localparam int PCB = IDX_W - HIST_W;

  logic clk = 0, rst_n = 0;
  logic [PC_W-1:0] fetch_pc = '0;
  logic dec_br = 0, dec_tk = 0;
  logic pred;

  hist_branch_pred #(.PC_W(PC_W), .PC_LO(PC_LO), .IDX_W(IDX_W), .HIST_W(HIST_W)) i_hist_branch_pred (
    .clk_i(clk), .rst_ni(rst_n), .fetch_pc_i(fetch_pc),
    .dec_is_br_i(dec_br), .dec_taken_i(dec_tk), .pred_taken_o(pred));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  int tbl [1 << IDX_W];
  int hist = 0;
  bit p_valid = 0, p_br = 0, p_tk = 0, p_exp = 0;
  string p_tag = "";

  function automatic int idx_of(int pc, int h);
    return (((pc >> PC_LO) & ((1 << PCB) - 1)) << HIST_W) | h;
  endfunction

  function automatic int step_cnt(int c, bit up);
    if (up) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: pred act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // present next instruction in fetch; previous moves to decode
  task automatic step(int pc, bit br, bit tk, string tag);
    int i;
    @(negedge clk);
    if (p_valid) check(p_tag, pred, p_exp);
    dec_br   = p_valid & p_br;
    dec_tk   = p_tk;
    fetch_pc = pc;
    if (p_valid && p_br) begin
      tbl[i_last] = step_cnt(tbl[i_last], p_tk);
      hist = ((hist << 1) | p_tk) & ((1 << HIST_W) - 1);
    end
    i = idx_of(pc, hist);
    i_last  = i;
    p_exp   = tbl[i][1];
    p_valid = 1; p_br = br; p_tk = tk; p_tag = tag;
  endtask
  int i_last = 0;

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    for (int k = 0; k < (1 << IDX_W); k++) tbl[k] = 1;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R8 reset", pred, 0);
    // saturation high then low, same PC back-to-back
    for (int k = 0; k < 8; k++) step(32'h100, 1, 1, "R3 R6 R7 sat-hi");
    step(32'h100, 1, 0, "R3 down");
    for (int k = 0; k < 10; k++) step(32'h100, 1, 0, "R3 R6 sat-lo");
    step(32'h100, 1, 1, "R3 up");
    // alternating outcomes on one branch
    for (int k = 0; k < 24; k++) step(32'h104, 1, k[0], "R5 R6 R7 alt");
    // non-branches interleaved must leave state untouched
    for (int k = 0; k < 30; k++) step(32'h200 + 4 * k, (k % 3) == 0, k[1], "R9 R4 mixed");
    // correlated random stream over aliasing PCs
    for (int k = 0; k < 400; k++) begin
      int pc;
      bit br, tk;
      pc = 32'h1000 + 4 * int'($urandom_range(0, 7));
      br = $urandom_range(0, 3) != 0;
      tk = ($urandom_range(0, 4) == 0) ? bit'($urandom_range(0, 1))
                                       : bit'(hist[0] ^ pc[2]);
      step(pc, br, tk, "R1 R2 R4 R5 rand");
    end
    step(32'h0, 0, 0, "R2 drain");
    step(32'h0, 0, 0, "R2 drain");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule